// File: doc/BRIEF.md
# Temperature Limit Alert Filter

This block sits between a temperature conversion engine and an active-low alert line. Each conversion arrives as a single strobe that carries one reading for an internal channel and one for an external channel. The external reading comes with a diode-fault flag. The block compares each reading against programmable high and low limits. A per-channel consecutive-event counter must reach a programmed count before the alert fires.

Two alert modes are available. In interrupt mode a qualified channel latches status and error bits, and those bits hold the alert low until software reads the status register. In comparator mode only over-limit readings count, and the alert releases once the reading falls below the high limit minus a hysteresis value. A small register port holds the limits, the hysteresis, the channel mask, the mode and the count field. Readings and limits are unsigned. Each is an integer byte, bit weights 128 down to 1, followed by FRAC fraction bits. The first fraction bit weighs 0.5.

Top module: `temp_alert_filter`

## Requirements
- R1: A reading sets HIGH when it is strictly greater than its high limit and sets LOW when it is less than or equal to its low limit. The comparison includes the fraction bits. A limit's fraction is written into bits 7..5 of its low-byte register.
- R2: After reset, alert_no is 1 and status is 0. The configuration register at 22h reads 70h. Both high limits read 55h, the low limits read 00h and the hysteresis (08h) reads 0Ah. Register map: internal high hi/lo 00h/01h, internal low 02h/03h, external high 04h/05h, external low 06h/07h, mask 09h, mode 0Ah (bit 0: 1 = comparator), status 0Bh.
- R3: Bits 2..0 of 22h set the count: 000 gives 1, 001 gives 2, 011 gives 3, 111 gives 4, and any other code gives 1. In interrupt mode a channel qualifies after that many consecutive conversions with an event. A conversion without an event clears that channel's counter.
- R4: In interrupt mode a qualifying channel latches its status bit and the error bits of that conversion, drives alert_no low and clears its counter. Status bits: 0 internal, 1 external, 2 internal HIGH, 3 internal LOW, 4 external HIGH, 5 external LOW, 6 external FAULT.
- R5: In interrupt mode, reading status (0Bh with reg_rd_i) returns the latched bits and then clears them, which releases alert_no. A qualification in the same cycle as the read wins, so its bits stay set.
- R6: A mask bit of 1 (bit 0 internal, bit 1 external) keeps that channel from driving alert_no. Its status and error bits still latch.
- R7: Only the external channel has a fault input. In interrupt mode a fault counts as an event and sets status bit 6.
- R8: In comparator mode only HIGH counts. LOW and FAULT act as clean conversions and clear the counter.
- R9: In comparator mode a channel that has reached its count holds alert_no low, and status bit 0 or 1 reads 1. This lasts until a conversion where reading + 8·hysteresis·2^-3·... is strictly below the high limit, that is, reading < high − hysteresis. A status read does not release it. On release the counter restarts from zero.
- R10: A register write without a conversion strobe changes neither alert_no nor status. The next conversion compares against the new limit.
- R11: When one channel qualifies, the other channel's counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | Conversion strobe, one cycle |
| int_temp_i | input | 8+FRAC | Internal channel reading |
| ext_temp_i | input | 8+FRAC | External channel reading |
| ext_fault_i | input | 1 | External diode fault with this conversion |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on status only) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| status_o | output | 7 | Current status view |
| alert_no | output | 1 | Shared alert, active low |

## Verification
The bench probes the exact limit boundaries: a reading equal to the high limit must not fire, and one fraction step above must. For LOW the boundary is the opposite, so equality fires; an off-by-one comparator would fire or stay quiet one step early. It sweeps every count encoding, including an illegal code. It also breaks a run with one clean conversion, which exposes a counter that is not cleared, a counter not restarted after a qualification, and a wrong decode. A status read that coincides with a new qualification must leave the new bits set; a design that orders clear after set would drop that alert. In comparator mode the bench walks the reading down through the hysteresis point to the exact release value. It interleaves LOW and FAULT events, which a design that counts them would turn into an early alert.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;
  localparam int NUM_CH = 2;
  localparam int ST_W   = 7;
  localparam logic [7:0] A_HYST   = 8'h08;
  localparam logic [7:0] A_MASK   = 8'h09;
  localparam logic [7:0] A_MODE   = 8'h0A;
  localparam logic [7:0] A_STATUS = 8'h0B;
  localparam logic [7:0] A_CFG    = 8'h22;
  localparam logic [7:0] CFG_RST  = 8'h70;

  function automatic logic [2:0] cnt_limit(input logic [2:0] code);
    case (code)
      3'b001:  cnt_limit = 3'd2;
      3'b011:  cnt_limit = 3'd3;
      3'b111:  cnt_limit = 3'd4;
      default: cnt_limit = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/temp_alert_regs.sv
module temp_alert_regs
  import temp_alert_pkg::*;
#(
  parameter int FRAC = 3,
  localparam int TW  = 8 + FRAC
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [7:0]                   addr_i,
  input  logic [7:0]                   wdata_i,
  input  logic [ST_W-1:0]              status_i,
  output logic [7:0]                   rdata_o,
  output logic [NUM_CH-1:0][TW-1:0]    hi_lim_o,
  output logic [NUM_CH-1:0][TW-1:0]    lo_lim_o,
  output logic [7:0]                   hyst_o,
  output logic [NUM_CH-1:0]            mask_o,
  output logic                         comp_mode_o,
  output logic [2:0]                   cnt_code_o
);
  localparam int NLIM = 4 * NUM_CH;
  localparam logic [7:0] FRAC_MSK = ~(8'hFF >> FRAC);
  localparam logic [7:0] NLIM_B   = 8'(NLIM);

  logic [7:0]        lim_q [NLIM];
  logic [7:0]        hyst_q, cfg_q;
  logic [NUM_CH-1:0] mask_q;
  logic              mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NLIM; i++) lim_q[i] <= (i % 4 == 0) ? 8'h55 : 8'h00;
      hyst_q <= 8'h0A;
      cfg_q  <= CFG_RST;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i < NLIM_B)
        lim_q[addr_i[$clog2(NLIM)-1:0]] <= addr_i[0] ? (wdata_i & FRAC_MSK) : wdata_i;
      else begin
        case (addr_i)
          A_HYST: hyst_q <= wdata_i;
          A_MASK: mask_q <= wdata_i[NUM_CH-1:0];
          A_MODE: mode_q <= wdata_i[0];
          A_CFG:  cfg_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lim
    assign hi_lim_o[c] = {lim_q[4*c],   lim_q[4*c+1][7 -: FRAC]};
    assign lo_lim_o[c] = {lim_q[4*c+2], lim_q[4*c+3][7 -: FRAC]};
  end

  assign hyst_o      = hyst_q;
  assign mask_o      = mask_q;
  assign comp_mode_o = mode_q;
  assign cnt_code_o  = cfg_q[2:0];

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i < NLIM_B) rdata_o = lim_q[addr_i[$clog2(NLIM)-1:0]];
    else begin
      case (addr_i)
        A_HYST:   rdata_o = hyst_q;
        A_MASK:   rdata_o = 8'(mask_q);
        A_MODE:   rdata_o = {7'd0, mode_q};
        A_STATUS: rdata_o = 8'(status_i);
        A_CFG:    rdata_o = cfg_q;
        default:  rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/temp_alert_chan.sv
module temp_alert_chan #(
  parameter int TW = 11,
  parameter int FRAC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic [7:0]    hyst_i,
  input  logic          fault_i,
  input  logic          comp_i,
  input  logic [2:0]    limit_i,
  output logic          qual_o,
  output logic          ev_hi_o,
  output logic          ev_lo_o,
  output logic          active_o,
  output logic [2:0]    cnt_o
);
  logic [2:0]  cnt_q;
  logic        act_q;
  logic        ev, reach, release_ok;
  logic [3:0]  cnt_inc;
  logic [TW:0] rel_sum;

  assign ev_hi_o    = temp_i > hi_i;
  assign ev_lo_o    = temp_i <= lo_i;
  assign ev         = comp_i ? ev_hi_o : (ev_hi_o | ev_lo_o | fault_i);
  assign cnt_inc    = {1'b0, cnt_q} + 4'd1;
  assign reach      = cnt_inc >= {1'b0, limit_i};
  // reading + hysteresis < high  <=>  reading < high - hysteresis, no underflow
  assign rel_sum    = {1'b0, temp_i} + (TW + 1)'({hyst_i, {FRAC{1'b0}}});
  assign release_ok = rel_sum < {1'b0, hi_i};
  assign qual_o     = conv_i & ~comp_i & ev & reach;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (conv_i) begin
      if (!comp_i) begin
        if (!ev || reach) cnt_q <= '0;
        else              cnt_q <= cnt_inc[2:0];
      end else if (act_q) begin
        if (release_ok) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end
      end else if (ev) begin
        cnt_q <= cnt_inc[2:0];
        if (reach) act_q <= 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign active_o = act_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/temp_alert_filter.sv
module temp_alert_filter
  import temp_alert_pkg::*;
#(
  parameter int FRAC = 3,
  localparam int TW  = 8 + FRAC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            conv_valid_i,
  input  logic [TW-1:0]   int_temp_i,
  input  logic [TW-1:0]   ext_temp_i,
  input  logic            ext_fault_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [7:0]      reg_addr_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic [ST_W-1:0] status_o,
  output logic            alert_no
);
  logic [NUM_CH-1:0][TW-1:0] hi_lim, lo_lim, temp_v;
  logic [NUM_CH-1:0]         mask, fault_v, qual, ev_hi, ev_lo, active, alert_src;
  logic [NUM_CH-1:0][2:0]    cnt;
  logic [7:0]                hyst;
  logic                      comp_mode, rd_clr;
  logic [2:0]                cnt_code, limit;
  logic [ST_W-1:0]           st_q, st_set;
  logic [2:0]                cnt_int, cnt_ext;

  temp_alert_regs #(.FRAC(FRAC)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(status_o), .rdata_o(reg_rdata_o),
    .hi_lim_o(hi_lim), .lo_lim_o(lo_lim), .hyst_o(hyst),
    .mask_o(mask), .comp_mode_o(comp_mode), .cnt_code_o(cnt_code)
  );

  assign limit   = cnt_limit(cnt_code);
  assign temp_v  = {ext_temp_i, int_temp_i};
  assign fault_v = {ext_fault_i, 1'b0};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    temp_alert_chan #(.TW(TW), .FRAC(FRAC)) u_chan (
      .clk_i, .rst_ni,
      .conv_i(conv_valid_i), .temp_i(temp_v[c]),
      .hi_i(hi_lim[c]), .lo_i(lo_lim[c]), .hyst_i(hyst),
      .fault_i(fault_v[c]), .comp_i(comp_mode), .limit_i(limit),
      .qual_o(qual[c]), .ev_hi_o(ev_hi[c]), .ev_lo_o(ev_lo[c]),
      .active_o(active[c]), .cnt_o(cnt[c])
    );
  end

  assign cnt_int = cnt[0];
  assign cnt_ext = cnt[1];

  assign st_set = {qual[1] & ext_fault_i, qual[1] & ev_lo[1], qual[1] & ev_hi[1],
                   qual[0] & ev_lo[0], qual[0] & ev_hi[0], qual};
  assign rd_clr = reg_rd_i && (reg_addr_i == A_STATUS) && !comp_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (rd_clr ? '0 : st_q) | st_set;
  end

  assign status_o  = comp_mode ? ST_W'(active) : st_q;
  assign alert_src = comp_mode ? active : st_q[NUM_CH-1:0];
  assign alert_no  = ~|(alert_src & ~mask);
endmodule

// File: rtl/temp_alert_filter_chk.sv
module temp_alert_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_valid_i,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [7:0] reg_addr_i,
  input logic       alert_no,
  input logic       comp_i,
  input logic [2:0] cnt_int_i,
  input logic [2:0] cnt_ext_i
);
  p_fall_needs_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_no) |-> $past(conv_valid_i || reg_wr_i));

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_int_i <= 3'd4) && (cnt_ext_i <= 3'd4));

  p_rd_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 8'h0B && !conv_valid_i && !reg_wr_i && !comp_i) |=> alert_no);

  p_cmp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_i && !alert_no && !conv_valid_i && !reg_wr_i) |=> !alert_no);

  p_write_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_valid_i && !reg_rd_i && !(reg_wr_i && (reg_addr_i == 8'h09 || reg_addr_i == 8'h0A)))
      |=> $stable(alert_no));
endmodule

bind temp_alert_filter temp_alert_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .conv_valid_i(conv_valid_i),
  .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .alert_no(alert_no), .comp_i(comp_mode),
  .cnt_int_i(cnt_int), .cnt_ext_i(cnt_ext)
);

// File: tb/temp_alert_filter_tb.sv
module temp_alert_filter_tb;
  localparam int FRAC = 3;
  localparam int TW = 8 + FRAC;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic conv_valid_i = 1'b0, ext_fault_i = 1'b0;
  logic [TW-1:0] int_temp_i = '0, ext_temp_i = '0;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic [6:0] status_o;
  logic alert_no;

  int total = 0, bad = 0;

  typedef struct {
    string      tag;
    logic       alert;
    logic [6:0] st;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  always #5 clk_i = ~clk_i;

  temp_alert_filter #(.FRAC(FRAC)) u_dut (.*);

  function automatic logic [TW-1:0] t(input int deg, input int frac);
    return {8'(deg), 3'(frac)};
  endfunction

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk_i) begin
    while (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      total++;
      if (alert_no !== cur.alert || status_o !== cur.st) begin
        bad++;
        $display("FAIL %s: alert=%b st=%02h expected alert=%b st=%02h",
                 cur.tag, alert_no, status_o, cur.alert, cur.st);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic expect_o(input string tag, input logic a, input logic [6:0] s);
    exp_t e;
    e.tag = tag; e.alert = a; e.st = s;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_wr_i = 1'b0;
  endtask

  task automatic conv(input logic [TW-1:0] it, input logic [TW-1:0] et, input logic f,
                      input string tag, input logic a, input logic [6:0] s);
    conv_valid_i = 1'b1; int_temp_i = it; ext_temp_i = et; ext_fault_i = f;
    cyc();
    conv_valid_i = 1'b0; ext_fault_i = 1'b0;
    expect_o(tag, a, s);
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr_i = a; #1;
    total++;
    if (reg_rdata_o !== e) begin
      bad++;
      $display("FAIL %s: reg %02h=%02h expected %02h", tag, a, reg_rdata_o, e);
    end
  endtask

  // status read: checks returned value, then checks outputs after the read
  task automatic rd_st(input logic [6:0] e, input string tag, input logic a, input logic [6:0] s);
    chk_reg(8'h0B, {1'b0, e}, tag);
    reg_rd_i = 1'b1;
    cyc();
    reg_rd_i = 1'b0;
    expect_o(tag, a, s);
  endtask

  task automatic clean(input string tag);
    conv(t(50, 0), t(50, 0), 1'b0, tag, 1'b1, 7'h00);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R2 reset state
    expect_o("R2 reset outputs", 1'b1, 7'h00);
    chk_reg(8'h22, 8'h70, "R2 cfg");
    chk_reg(8'h00, 8'h55, "R2 int high");
    chk_reg(8'h04, 8'h55, "R2 ext high");
    chk_reg(8'h02, 8'h00, "R2 int low");
    chk_reg(8'h08, 8'h0A, "R2 hyst");

    // R1 boundaries
    conv(t(85, 0), t(50, 0), 1'b0, "R1 equal high", 1'b1, 7'h00);
    conv(t(85, 1), t(50, 0), 1'b0, "R1 high+0.125", 1'b0, 7'h05);
    rd_st(7'h05, "R1 read high", 1'b1, 7'h00);
    wr(8'h02, 8'd20);
    wr(8'h03, 8'h20);  // internal low = 20.125
    conv(t(20, 1), t(50, 0), 1'b0, "R1 equal low", 1'b0, 7'h09);
    rd_st(7'h09, "R1 read low", 1'b1, 7'h00);
    conv(t(20, 2), t(50, 0), 1'b0, "R1 low+0.125", 1'b1, 7'h00);

    // R3 count of 3
    wr(8'h22, 8'h73);
    clean("R3 clean");
    conv(t(90, 0), t(50, 0), 1'b0, "R3 n1", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 n2", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 n3", 1'b0, 7'h05);
    rd_st(7'h05, "R3 read", 1'b1, 7'h00);
    // R4 counter cleared on qualify
    conv(t(90, 0), t(50, 0), 1'b0, "R4 n1", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R4 n2", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R4 n3", 1'b0, 7'h05);
    rd_st(7'h05, "R4 read", 1'b1, 7'h00);
    // R3 a clean conversion breaks the run
    conv(t(90, 0), t(50, 0), 1'b0, "R3 break a", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 break b", 1'b1, 7'h00);
    clean("R3 break clean");
    conv(t(90, 0), t(50, 0), 1'b0, "R3 break c", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 break d", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 break e", 1'b0, 7'h05);
    rd_st(7'h05, "R3 break read", 1'b1, 7'h00);
    // R3 illegal code gives 1
    wr(8'h22, 8'h75);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 code101", 1'b0, 7'h05);
    rd_st(7'h05, "R3 code101 read", 1'b1, 7'h00);
    // R3 code 111 gives 4
    wr(8'h22, 8'h77);
    for (int i = 0; i < 3; i++) conv(t(90, 0), t(50, 0), 1'b0, "R3 code111 early", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 code111 fourth", 1'b0, 7'h05);
    rd_st(7'h05, "R3 code111 read", 1'b1, 7'h00);
    // R3 code 001 gives 2
    wr(8'h22, 8'h71);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 code001 first", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R3 code001 second", 1'b0, 7'h05);
    rd_st(7'h05, "R3 code001 read", 1'b1, 7'h00);

    // R5 read coinciding with a new qualification
    wr(8'h22, 8'h70);
    conv(t(90, 0), t(50, 0), 1'b0, "R5 first", 1'b0, 7'h05);
    reg_rd_i = 1'b1; reg_addr_i = 8'h0B;
    conv(t(90, 0), t(50, 0), 1'b0, "R5 read+qualify", 1'b0, 7'h05);
    reg_rd_i = 1'b0;
    rd_st(7'h05, "R5 plain read", 1'b1, 7'h00);

    // R6 masking
    wr(8'h09, 8'h01);
    conv(t(90, 0), t(50, 0), 1'b0, "R6 int masked", 1'b1, 7'h05);
    rd_st(7'h05, "R6 int read", 1'b1, 7'h00);
    wr(8'h09, 8'h02);
    conv(t(50, 0), t(90, 0), 1'b0, "R6 ext masked", 1'b1, 7'h12);
    rd_st(7'h12, "R6 ext read", 1'b1, 7'h00);
    wr(8'h09, 8'h00);

    // R7 fault
    conv(t(50, 0), t(50, 0), 1'b1, "R7 fault", 1'b0, 7'h42);
    rd_st(7'h42, "R7 read", 1'b1, 7'h00);

    // R11 independent counters, count of 3
    wr(8'h22, 8'h73);
    clean("R11 clean");
    conv(t(90, 0), t(50, 0), 1'b0, "R11 c1", 1'b1, 7'h00);
    conv(t(90, 0), t(90, 0), 1'b0, "R11 c2", 1'b1, 7'h00);
    conv(t(90, 0), t(90, 0), 1'b0, "R11 c3 int", 1'b0, 7'h05);
    rd_st(7'h05, "R11 read int", 1'b1, 7'h00);
    conv(t(50, 0), t(90, 0), 1'b0, "R11 c4 ext", 1'b0, 7'h12);
    rd_st(7'h12, "R11 read ext", 1'b1, 7'h00);

    // R10 writes take effect at next conversion only
    wr(8'h22, 8'h70);
    wr(8'h00, 8'h5F);
    expect_o("R10 write quiet", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R10 new high 95", 1'b1, 7'h00);
    wr(8'h00, 8'h50);
    expect_o("R10 write quiet 2", 1'b1, 7'h00);
    conv(t(82, 0), t(50, 0), 1'b0, "R10 new high 80", 1'b0, 7'h05);
    rd_st(7'h05, "R10 read", 1'b1, 7'h00);
    wr(8'h00, 8'h55);

    // R8/R9 comparator mode, count of 2
    wr(8'h0A, 8'h01);
    wr(8'h22, 8'h71);
    clean("R8 clean");
    for (int i = 0; i < 3; i++) conv(t(10, 0), t(50, 0), 1'b0, "R8 low ignored", 1'b1, 7'h00);
    for (int i = 0; i < 2; i++) conv(t(50, 0), t(50, 0), 1'b1, "R8 fault ignored", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R9 first high", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R9 second high", 1'b0, 7'h01);
    rd_st(7'h01, "R9 read no release", 1'b0, 7'h01);
    conv(t(80, 0), t(50, 0), 1'b0, "R9 in band", 1'b0, 7'h01);
    conv(t(75, 0), t(50, 0), 1'b0, "R9 at release point", 1'b0, 7'h01);
    conv(t(74, 7), t(50, 0), 1'b0, "R9 below release", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R9 restart count", 1'b1, 7'h00);
    conv(t(10, 0), t(50, 0), 1'b0, "R8 low breaks run", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R8 after break", 1'b1, 7'h00);
    conv(t(90, 0), t(50, 0), 1'b0, "R8 second high", 1'b0, 7'h01);

    repeat (3) cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule